// File: doc/BRIEF.md
# Machine-Mode Trap Entry Controller

This block keeps the machine-mode trap state of a small RISC-V style core and computes where instruction fetch goes next when a trap is taken, when a return-from-trap executes, and right after reset. It holds four registers: the saved exception PC, the status bits with the interrupt enable and its previous value, the trap vector base with its dispatch mode, and the trap cause. The pipeline raises a trap request with a cause code and an interrupt flag, or a return request. The block answers one clock later with a redirect strobe and the new fetch address.

An exception always goes to the vector base. An interrupt goes to the base in direct mode. In vectored mode it goes to the base plus four times its ID. The vector base is held to 256-byte alignment. Traps are not nested in hardware: a trap taken inside a handler simply overwrites the saved PC and status. Software reads and writes the registers through a small CSR port with a two-bit register select.

Top module: `mtrap_unit`

## Requirements
- R1: On the first rising clock edge after `rst_n` is released, `redirect` pulses for one cycle with `redirect_pc` equal to `boot_addr`. A trap or return request presented in that same cycle has no effect, and after reset the interrupt enable (`irq_en`) is 0.
- R2: A trap request accepted at a clock edge gives `redirect`=1 in the next cycle. At the same edge the saved PC takes `cur_pc`, the previous-enable bit takes the old enable, the enable is cleared, and the cause register takes `{trap_is_irq` in bit 31, `trap_cause` in bits 4:0`}`.
- R3: For an exception (`trap_is_irq`=0), the redirect target is the vector base in both modes.
- R4: For an interrupt, the redirect target is the base in direct mode (vector register bit 0 = 0) and base + 4×`trap_cause` in vectored mode (bit 0 = 1).
- R5: A return request redirects to the saved PC. It also copies the previous-enable bit into the enable and sets the previous-enable bit to 1.
- R6: A write to the vector register stores bit 0 as the mode. It reads back with bits 7:1 as zero and bits 31:8 as written.
- R7: A trap and a return requested in the same cycle: the trap is taken and the return is dropped. A trap in the same cycle as a CSR write to the saved PC, status or cause: the trap values win.
- R8: A trap taken while the enable is 0 overwrites the saved PC and leaves the previous-enable bit at 0.
- R9: CSR select 0 reads the status, with the enable in bit 3 and the previous-enable bit in bit 7. Select 1 reads the vector register, select 2 the saved PC and select 3 the cause. Reads are combinational.
- R10: `redirect` is 0 in any cycle that follows no boot, trap or return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_addr | input | 32 | Registered fetch address used after reset |
| cur_pc | input | 32 | PC of the instruction taking the trap |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | 1: interrupt, 0: exception |
| trap_cause | input | 5 | Exception code or interrupt ID |
| mret_req | input | 1 | Return from trap this cycle |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | Register select (see R9) |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| irq_en | output | 1 | Current global interrupt enable |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
The bench uses the default parameters: 32-bit words, 5-bit cause codes and 256-byte vector alignment. With these, the largest vectored offset (31×4) fits under the alignment boundary. Every interrupt ID therefore lands inside the vector table, and an exception target can be checked as a pure base with a zero low byte. Vector bases with high bits set and IDs such as 11 and 7 show that the offset sits only in bits 7:2, in both dispatch modes.

// File: rtl/mtrap_pkg.sv
// Package: shared constants for the trap controller.
// Assumes a CSR select of two bits and the standard status bit positions.
package mtrap_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_VECTOR = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_CAUSE  = 2'd3
    } csr_sel_e;

    localparam int STAT_EN_BIT  = 3;
    localparam int STAT_PEN_BIT = 7;
endpackage

// File: rtl/mtrap_csr.sv
// Module: trap state registers (saved PC, enable bits, vector, cause).
// Assumes enter/leave are already arbitrated; trap state updates win over
// software writes in the same cycle. ALIGN must be at least ID_W+2.
module mtrap_csr #(
    parameter int XLEN  = 32,
    parameter int ID_W  = 5,
    parameter int ALIGN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic              leave,
    input  logic [XLEN-1:0]   entry_pc,
    input  logic              entry_irq,
    input  logic [ID_W-1:0]   entry_code,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              en_q,
    output logic              pen_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-ALIGN-1:0] vbase_q,
    output logic              vmode_q
);
    import mtrap_pkg::*;

    localparam int PAD_C = XLEN - 1 - ID_W;

    logic              cirq_q;
    logic [ID_W-1:0]   ccode_q;
    logic              wr_stat, wr_vec, wr_epc, wr_cause;

    // Decode software write strobes per register.
    always_comb begin
        wr_stat  = csr_we && (csr_sel == SEL_STATUS);
        wr_vec   = csr_we && (csr_sel == SEL_VECTOR);
        wr_epc   = csr_we && (csr_sel == SEL_EPC);
        wr_cause = csr_we && (csr_sel == SEL_CAUSE);
    end

    // Enable and previous-enable bits: trap entry, return, then software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            pen_q <= 1'b0;
        end else if (enter) begin
            pen_q <= en_q;
            en_q  <= 1'b0;
        end else if (leave) begin
            en_q  <= pen_q;
            pen_q <= 1'b1;
        end else if (wr_stat) begin
            en_q  <= csr_wdata[STAT_EN_BIT];
            pen_q <= csr_wdata[STAT_PEN_BIT];
        end
    end

    // Saved exception PC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc_q <= '0;
        else if (enter)
            epc_q <= entry_pc;
        else if (wr_epc)
            epc_q <= csr_wdata;
    end

    // Trap cause: interrupt flag and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cirq_q  <= 1'b0;
            ccode_q <= '0;
        end else if (enter) begin
            cirq_q  <= entry_irq;
            ccode_q <= entry_code;
        end else if (wr_cause) begin
            cirq_q  <= csr_wdata[XLEN-1];
            ccode_q <= csr_wdata[ID_W-1:0];
        end
    end

    // Vector base (aligned bits only) and dispatch mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbase_q <= '0;
            vmode_q <= 1'b0;
        end else if (wr_vec) begin
            vbase_q <= csr_wdata[XLEN-1:ALIGN];
            vmode_q <= csr_wdata[0];
        end
    end

    // Combinational read mux.
    always_comb begin
        csr_rdata = '0;
        unique case (csr_sel)
            SEL_STATUS: begin
                csr_rdata[STAT_EN_BIT]  = en_q;
                csr_rdata[STAT_PEN_BIT] = pen_q;
            end
            SEL_VECTOR: csr_rdata = {vbase_q, {(ALIGN-1){1'b0}}, vmode_q};
            SEL_EPC:    csr_rdata = epc_q;
            SEL_CAUSE:  csr_rdata = {cirq_q, {PAD_C{1'b0}}, ccode_q};
            default:    csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mtrap_target.sv
// Module: computes the trap handler address from vector base, mode and cause.
// Assumes the vectored offset (code*4) fits below the alignment boundary.
module mtrap_target #(
    parameter int XLEN  = 32,
    parameter int ID_W  = 5,
    parameter int ALIGN = 8
) (
    input  logic [XLEN-ALIGN-1:0] vbase,
    input  logic                  vmode,
    input  logic                  is_irq,
    input  logic [ID_W-1:0]       code,
    output logic [XLEN-1:0]       target
);
    localparam int OFS_PAD = ALIGN - ID_W - 2;

    logic [ALIGN-1:0] offset;

    // Offset only for interrupts in vectored mode.
    always_comb begin
        offset = '0;
        if (is_irq && vmode)
            offset = {{OFS_PAD{1'b0}}, code, 2'b00};
        target = {vbase, offset};
    end
endmodule

// File: rtl/mtrap_redirect.sv
// Module: registers the fetch redirect for boot, trap entry and return.
// Assumes the caller has already given trap priority over return.
module mtrap_redirect #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] boot_addr,
    input  logic            enter,
    input  logic            leave,
    input  logic [XLEN-1:0] trap_target,
    input  logic [XLEN-1:0] epc,
    output logic            boot_pend,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc
);
    // One boot redirect after reset release, then trap/return redirects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_pend   <= 1'b1;
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else if (boot_pend) begin
            boot_pend   <= 1'b0;
            redirect    <= 1'b1;
            redirect_pc <= boot_addr;
        end else if (enter) begin
            redirect    <= 1'b1;
            redirect_pc <= trap_target;
        end else if (leave) begin
            redirect    <= 1'b1;
            redirect_pc <= epc;
        end else begin
            redirect    <= 1'b0;
        end
    end
endmodule

// File: rtl/mtrap_unit.sv
// Module: machine-mode trap entry/return controller top.
// Assumes requests are single-cycle strobes from the pipeline; requests
// during the boot cycle are dropped.
module mtrap_unit #(
    parameter int XLEN  = 32,
    parameter int ID_W  = 5,
    parameter int ALIGN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] boot_addr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            trap_req,
    input  logic            trap_is_irq,
    input  logic [ID_W-1:0] trap_cause,
    input  logic            mret_req,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            irq_en,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc
);
    logic                  boot_pend;
    logic                  enter, leave;
    logic                  en_q, pen_q, vmode_q;
    logic [XLEN-1:0]       epc_q, trap_target;
    logic [XLEN-ALIGN-1:0] vbase_q;

    // Arbitration: boot blocks all, trap beats return.
    always_comb begin
        enter = trap_req && !boot_pend;
        leave = mret_req && !trap_req && !boot_pend;
    end

    assign irq_en = en_q;

    mtrap_csr #(.XLEN(XLEN), .ID_W(ID_W), .ALIGN(ALIGN)) u_csr (
        .clk(clk), .rst_n(rst_n), .enter(enter), .leave(leave),
        .entry_pc(cur_pc), .entry_irq(trap_is_irq), .entry_code(trap_cause),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .en_q(en_q), .pen_q(pen_q), .epc_q(epc_q),
        .vbase_q(vbase_q), .vmode_q(vmode_q)
    );

    mtrap_target #(.XLEN(XLEN), .ID_W(ID_W), .ALIGN(ALIGN)) u_tgt (
        .vbase(vbase_q), .vmode(vmode_q), .is_irq(trap_is_irq),
        .code(trap_cause), .target(trap_target)
    );

    mtrap_redirect #(.XLEN(XLEN)) u_redir (
        .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .enter(enter),
        .leave(leave), .trap_target(trap_target), .epc(epc_q),
        .boot_pend(boot_pend), .redirect(redirect), .redirect_pc(redirect_pc)
    );
endmodule

// File: rtl/mtrap_unit_chk.sv
// Module: assertion checker bound into mtrap_unit.
// Assumes it observes the top ports plus the boot flag and trap state.
module mtrap_unit_chk #(
    parameter int XLEN  = 32,
    parameter int ALIGN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boot_pend,
    input logic            trap_req,
    input logic            trap_is_irq,
    input logic            mret_req,
    input logic [XLEN-1:0] cur_pc,
    input logic [1:0]      csr_sel,
    input logic [XLEN-1:0] csr_rdata,
    input logic            irq_en,
    input logic            pen_q,
    input logic [XLEN-1:0] epc_q,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc
);
    AST_TRAP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !boot_pend) |=> (redirect && !irq_en && pen_q == $past(irq_en))); // R2
    AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !boot_pend) |=> (epc_q == $past(cur_pc))); // R2
    AST_EXC_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_is_irq && !boot_pend) |=> (redirect_pc[ALIGN-1:0] == '0)); // R3
    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_req && !boot_pend) |=>
        (redirect && redirect_pc == $past(epc_q) && irq_en == $past(pen_q) && pen_q)); // R5
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_sel == 2'd1) |-> (csr_rdata[ALIGN-1:1] == '0)); // R6
    AST_NO_STRAY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(trap_req || mret_req || boot_pend)); // R10
endmodule

bind mtrap_unit mtrap_unit_chk #(.XLEN(XLEN), .ALIGN(ALIGN)) u_chk (
    .clk(clk), .rst_n(rst_n), .boot_pend(boot_pend), .trap_req(trap_req),
    .trap_is_irq(trap_is_irq), .mret_req(mret_req), .cur_pc(cur_pc),
    .csr_sel(csr_sel), .csr_rdata(csr_rdata), .irq_en(irq_en), .pen_q(pen_q),
    .epc_q(epc_q), .redirect(redirect), .redirect_pc(redirect_pc)
);

// File: tb/tb_mtrap_unit.sv
// Scoreboard bench: driver tasks queue expected redirect targets, a monitor
// pops one per observed redirect; CSR state is checked through the CSR port.
module tb_mtrap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] boot_addr = 32'h0000_8000;
    logic [31:0] cur_pc = '0;
    logic        trap_req = 1'b0, trap_is_irq = 1'b0, mret_req = 1'b0;
    logic [4:0]  trap_cause = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq_en, redirect;
    logic [31:0] redirect_pc;

    int checks = 0, fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mtrap_unit dut (
        .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .cur_pc(cur_pc),
        .trap_req(trap_req), .trap_is_irq(trap_is_irq), .trap_cause(trap_cause),
        .mret_req(mret_req), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_en(irq_en),
        .redirect(redirect), .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every redirect must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && redirect) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected redirect", redirect_pc, 32'hxxxx_xxxx);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, redirect_pc, e);
            end
        end
    end

    task automatic csr_read(input string req, input logic [1:0] sel, input logic [31:0] exp);
        csr_sel = sel;
        #1;
        check(req, csr_rdata, exp);
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] d);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 1'b0;
        @(negedge clk);
    endtask

    // Driver: trap (optionally with return or CSR write in the same cycle).
    task automatic drive(input bit trap, input bit irq, input logic [4:0] code,
                         input bit ret, input logic [31:0] pc,
                         input logic [31:0] exp, input string tag);
        trap_req = trap; trap_is_irq = irq; trap_cause = code;
        mret_req = ret; cur_pc = pc;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        trap_req = 1'b0; mret_req = 1'b0; csr_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        csr_read("R1 status after reset", 2'd0, 32'h0);
        check("R1 enable after reset", {31'b0, irq_en}, 32'h0);
        // Release reset with a trap and a return request pending: both dropped.
        rst_n = 1'b1; trap_req = 1'b1; mret_req = 1'b1; cur_pc = 32'h0000_0AAA;
        trap_cause = 5'd2;
        exp_q.push_back(32'h0000_8000); tag_q.push_back("R1 boot redirect");
        @(posedge clk); #1;
        trap_req = 1'b0; mret_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        csr_read("R1 boot-cycle trap dropped (cause)", 2'd3, 32'h0);
        csr_read("R1 boot-cycle trap dropped (epc)", 2'd2, 32'h0);

        csr_write(2'd0, 32'h0000_0008);
        csr_read("R9 status write", 2'd0, 32'h0000_0008);
        csr_write(2'd1, 32'h0000_12FF);
        csr_read("R6 vector alignment", 2'd1, 32'h0000_1201);

        drive(1, 0, 5'd2, 0, 32'h100, 32'h0000_1200, "R3 exception in vectored mode");
        csr_read("R2 epc", 2'd2, 32'h100);
        csr_read("R2 status on entry", 2'd0, 32'h80);
        csr_read("R2 cause", 2'd3, 32'h2);

        drive(0, 0, 5'd0, 1, 32'h0, 32'h100, "R5 return target");
        csr_read("R5 status after return", 2'd0, 32'h88);

        drive(1, 1, 5'd11, 0, 32'h180, 32'h0000_122C, "R4 vectored interrupt 11");
        csr_read("R2 interrupt cause", 2'd3, 32'h8000_000B);

        drive(1, 0, 5'd3, 0, 32'h200, 32'h0000_1200, "R8 nested trap target");
        csr_read("R8 epc overwritten", 2'd2, 32'h200);
        csr_read("R8 status after nested trap", 2'd0, 32'h0);

        drive(0, 0, 5'd0, 1, 32'h0, 32'h200, "R5 return after nested");
        csr_read("R5 previous-enable set", 2'd0, 32'h80);

        csr_write(2'd1, 32'h0000_4000);
        drive(1, 1, 5'd7, 0, 32'h280, 32'h0000_4000, "R4 direct interrupt 7");

        drive(1, 0, 5'd11, 1, 32'h300, 32'h0000_4000, "R7 trap beats return");
        csr_read("R7 epc from trap", 2'd2, 32'h300);

        csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = 32'hDEAD_0000;
        drive(1, 0, 5'd2, 0, 32'h400, 32'h0000_4000, "R7 trap with csr write");
        csr_read("R7 epc keeps trap pc", 2'd2, 32'h400);

        repeat (3) @(negedge clk);
        check("R10 all expected redirects seen", exp_q.size(), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule